// File: doc/BRIEF.md
# Security-Banked System Handler State Register

This block holds the active, pending and enable flags of the system exception handlers in a processor with two security states. It appears as one 32-bit word on a simple register bus. The bus has decoded read and write strobes, write data, combinational read data, a secure attribute for each access, and a separate input that gives the processor's current security state. Most handler flags have two copies, one per security state, and the secure attribute of an access selects which copy that access sees. The bus-fault and NMI state appears to non-secure software only when a routing configuration input places those exceptions in the non-secure world. The security-fault flags are visible only to secure accesses.

The complete flag state leaves the block on a flat vector for an external prioritisation unit. An external exception sequencer updates the active and pending flags through single-cycle set and clear inputs. The `LEGACY` parameter selects an older register layout, which hides the hard-fault and NMI state from non-secure readers.

Top module: `shr_bank`

## Requirements
- R1: Memory-fault active (bit 0), usage-fault active (bit 3), supervisor-call active (bit 7), pendable-service active (bit 10), system-tick active (bit 11), usage pending (bit 12), memory pending (bit 13), supervisor-call pending (bit 15), memory enable (bit 16) and usage enable (bit 18) are banked. A secure access reads and writes the secure copy. A non-secure access reads and writes the non-secure copy.
- R2: Security-fault active (bit 4), enable (bit 19) and pending (bit 20) exist once. Secure accesses can read and write them. Non-secure accesses read them as zero, and non-secure writes leave them unchanged.
- R3: Bus-fault active (bit 1), pending (bit 14) and enable (bit 17) exist once. They can be read and written when the access is secure or `route_ns` is 1. Otherwise they read as zero and writes leave them unchanged.
- R4: NMI active (bit 5) reads back under the same condition as the bus-fault flags, and only when `LEGACY` is 0. Hard-fault active (bit 2) and hard-fault pending (bit 21) show the secure copy to secure reads. They show the non-secure copy to non-secure reads, and read as zero to non-secure reads when `LEGACY` is 1.
- R5: A register write never changes the secure hard-fault active or secure hard-fault pending flag.
- R6: A non-secure write loads bit 21 into the non-secure hard-fault pending flag when `LEGACY` is 0. When `LEGACY` is 1 the write leaves that flag unchanged.
- R7: A register write changes NMI active or non-secure hard-fault active only to clear it, and only when all four of these hold: the written bit (5 or 2) is 0, the access is non-secure, `cpu_secure` is 1 and `route_ns` is 1. No register write ever sets either flag.
- R8: Debug-monitor active (bit 8) exists once. Accesses from either security state can read and write it.
- R9: Bits 6, 9 and 22 to 31 always read as zero. Reset clears every flag.
- R10: `rdata` is combinational from the state and the access attributes while `rd_en` is 1, and is zero while `rd_en` is 0. A write takes effect on the rising edge where `wr_en` is 1.
- R11: `hw_set` and `hw_clr` act on every active and pending flag. If both hit the same flag in the same cycle, the clear wins. Both inputs have no effect on enable flags. If a register write and either input hit the same flag in the same cycle, the register write wins.
- R12: `flags_o`, `hw_set` and `hw_clr` share one index layout. Indices 0 to 11 are the secure bank and indices 12 to 23 the non-secure bank. Within each bank the order is: memory active, hard active, usage active, supervisor-call active, pendable-service active, system-tick active, memory pending, usage pending, supervisor-call pending, hard pending, memory enable, usage enable. Indices 24 to 31 are bus active, bus pending, bus enable, security-fault active, security-fault pending, security-fault enable, NMI active and debug-monitor active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Decoded read strobe for this register |
| wr_en | input | 1 | Decoded write strobe for this register |
| acc_secure | input | 1 | Secure attribute of the current access |
| cpu_secure | input | 1 | Current security state of the processor |
| route_ns | input | 1 | Bus fault, hard fault and NMI are routed to non-secure |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected view |
| hw_set | input | 32 | Sequencer set pulses, indexed as in R12 |
| hw_clr | input | 32 | Sequencer clear pulses, indexed as in R12 |
| flags_o | output | 32 | Complete flag state, indexed as in R12 |

## Verification
The assertions assume that `hw_set` and `hw_clr` are single-cycle pulses from a sequencer. They also assume that `rdata` is only looked at while `rd_en` is high. The secure hard-fault property (R5) excludes cycles in which the sequencer touches that flag, and the property that NMI is never set by a write (R7) assumes that only `hw_set` can raise it. The bench never drives the sequencer pulses together with register writes, except in the cycles that deliberately test the priority between them. It applies every combination of access attribute, processor state and routing to two instances, one with `LEGACY` 0 and one with `LEGACY` 1, under several data patterns.

// File: rtl/shr_pkg.sv
package shr_pkg;

  localparam int REG_W    = 32;
  localparam int BANK_N   = 12;
  localparam int SHR_N    = 8;
  localparam int FLAG_N   = 2 * BANK_N + SHR_N;
  localparam int NS_BASE  = BANK_N;
  localparam int SHR_BASE = 2 * BANK_N;

  // field order inside one bank
  localparam int K_MEM_ACT  = 0;
  localparam int K_HARD_ACT = 1;
  localparam int K_USE_ACT  = 2;
  localparam int K_SVC_ACT  = 3;
  localparam int K_PSV_ACT  = 4;
  localparam int K_TICK_ACT = 5;
  localparam int K_MEM_PEND = 6;
  localparam int K_USE_PEND = 7;
  localparam int K_SVC_PEND = 8;
  localparam int K_HARD_PEND = 9;
  localparam int K_MEM_EN   = 10;
  localparam int K_USE_EN   = 11;

  // shared flags in the flat state vector
  localparam int F_BUS_ACT  = SHR_BASE + 0;
  localparam int F_BUS_PEND = SHR_BASE + 1;
  localparam int F_BUS_EN   = SHR_BASE + 2;
  localparam int F_SF_ACT   = SHR_BASE + 3;
  localparam int F_SF_PEND  = SHR_BASE + 4;
  localparam int F_SF_EN    = SHR_BASE + 5;
  localparam int F_NMI_ACT  = SHR_BASE + 6;
  localparam int F_DBG_ACT  = SHR_BASE + 7;

  // register bit positions of the non-banked fields
  localparam int RB_BUS_ACT   = 1;
  localparam int RB_HARD_ACT  = 2;
  localparam int RB_SF_ACT    = 4;
  localparam int RB_NMI_ACT   = 5;
  localparam int RB_DBG_ACT   = 8;
  localparam int RB_BUS_PEND  = 14;
  localparam int RB_BUS_EN    = 17;
  localparam int RB_SF_EN     = 19;
  localparam int RB_SF_PEND   = 20;
  localparam int RB_HARD_PEND = 21;

  localparam logic [REG_W-1:0] RSV_MASK = 32'hFFC0_0240;

  // register bit carrying bank field k
  function automatic int bank_pos(input int k);
    case (k)
      K_MEM_ACT:   return 0;
      K_HARD_ACT:  return RB_HARD_ACT;
      K_USE_ACT:   return 3;
      K_SVC_ACT:   return 7;
      K_PSV_ACT:   return 10;
      K_TICK_ACT:  return 11;
      K_MEM_PEND:  return 13;
      K_USE_PEND:  return 12;
      K_SVC_PEND:  return 15;
      K_HARD_PEND: return RB_HARD_PEND;
      K_MEM_EN:    return 16;
      default:     return 18;
    endcase
  endfunction

  // flags reachable by the sequencer set/clear pulses (not enables)
  function automatic logic [FLAG_N-1:0] hw_mask();
    logic [FLAG_N-1:0] m;
    m = '1;
    for (int b = 0; b < 2; b++) begin
      m[b*BANK_N + K_MEM_EN] = 1'b0;
      m[b*BANK_N + K_USE_EN] = 1'b0;
    end
    m[F_BUS_EN] = 1'b0;
    m[F_SF_EN]  = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/shr_wr_decode.sv
module shr_wr_decode
  import shr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic              wr_en,
  input  logic              acc_secure,
  input  logic              cpu_secure,
  input  logic              route_ns,
  input  logic [REG_W-1:0]  wdata,
  output logic [FLAG_N-1:0] wr_mask,
  output logic [FLAG_N-1:0] wr_val
);

  logic shared_ok;
  logic clear_only_ok;

  assign shared_ok     = acc_secure | route_ns;
  assign clear_only_ok = !acc_secure && cpu_secure && route_ns;

  always_comb begin
    wr_mask = '0;
    wr_val  = '0;
    if (wr_en) begin
      // banked fields; hard-fault state is handled separately
      for (int k = 0; k < BANK_N; k++) begin
        if (k != K_HARD_ACT && k != K_HARD_PEND) begin
          if (acc_secure) begin
            wr_mask[k] = 1'b1;
            wr_val[k]  = wdata[bank_pos(k)];
          end else begin
            wr_mask[NS_BASE + k] = 1'b1;
            wr_val[NS_BASE + k]  = wdata[bank_pos(k)];
          end
        end
      end
      if (!acc_secure && !LEGACY) begin
        wr_mask[NS_BASE + K_HARD_PEND] = 1'b1;
        wr_val[NS_BASE + K_HARD_PEND]  = wdata[RB_HARD_PEND];
      end
      if (acc_secure) begin
        wr_mask[F_SF_ACT]  = 1'b1;
        wr_val[F_SF_ACT]   = wdata[RB_SF_ACT];
        wr_mask[F_SF_EN]   = 1'b1;
        wr_val[F_SF_EN]    = wdata[RB_SF_EN];
        wr_mask[F_SF_PEND] = 1'b1;
        wr_val[F_SF_PEND]  = wdata[RB_SF_PEND];
      end
      if (shared_ok) begin
        wr_mask[F_BUS_ACT]  = 1'b1;
        wr_val[F_BUS_ACT]   = wdata[RB_BUS_ACT];
        wr_mask[F_BUS_PEND] = 1'b1;
        wr_val[F_BUS_PEND]  = wdata[RB_BUS_PEND];
        wr_mask[F_BUS_EN]   = 1'b1;
        wr_val[F_BUS_EN]    = wdata[RB_BUS_EN];
      end
      // clear-only fields: value stays 0
      if (clear_only_ok && !wdata[RB_NMI_ACT]) begin
        wr_mask[F_NMI_ACT] = 1'b1;
      end
      if (clear_only_ok && !wdata[RB_HARD_ACT]) begin
        wr_mask[NS_BASE + K_HARD_ACT] = 1'b1;
      end
      wr_mask[F_DBG_ACT] = 1'b1;
      wr_val[F_DBG_ACT]  = wdata[RB_DBG_ACT];
    end
  end

endmodule

// File: rtl/shr_flag_store.sv
module shr_flag_store
  import shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] wr_mask,
  input  logic [FLAG_N-1:0] wr_val,
  input  logic [FLAG_N-1:0] hw_set,
  input  logic [FLAG_N-1:0] hw_clr,
  output logic [FLAG_N-1:0] q
);

  localparam logic [FLAG_N-1:0] HW_M = hw_mask();

  logic [FLAG_N-1:0] set_v;
  logic [FLAG_N-1:0] clr_v;
  logic [FLAG_N-1:0] hw_nxt;
  logic [FLAG_N-1:0] nxt;

  assign set_v  = hw_set & HW_M;
  assign clr_v  = hw_clr & HW_M;
  // clear beats set, register write beats both
  assign hw_nxt = (q | set_v) & ~clr_v;
  assign nxt    = (hw_nxt & ~wr_mask) | (wr_val & wr_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_chk
    // R11
    reg_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask[i] |=> q[i] == $past(wr_val[i]));
    if (!HW_M[i]) begin : g_en
      // R11
      enable_hw_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask[i] |=> $stable(q[i]));
    end
  end

endmodule

// File: rtl/shr_read_view.sv
module shr_read_view
  import shr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] q,
  input  logic              rd_en,
  input  logic              acc_secure,
  input  logic              route_ns,
  output logic [REG_W-1:0]  rdata
);

  logic [BANK_N-1:0] sel_bank;
  logic [BANK_N-1:0] bank_bits;
  logic [REG_W-1:0]  bank_v;
  logic [REG_W-1:0]  shr_v;

  assign sel_bank = acc_secure ? q[BANK_N-1:0] : q[NS_BASE +: BANK_N];

  for (genvar k = 0; k < BANK_N; k++) begin : g_bank
    localparam bit HIDE_NS = LEGACY && (k == K_HARD_ACT || k == K_HARD_PEND);
    if (HIDE_NS) begin : g_hide
      assign bank_bits[k] = sel_bank[k] & acc_secure;
    end else begin : g_show
      assign bank_bits[k] = sel_bank[k];
    end
  end

  always_comb begin
    bank_v = '0;
    for (int k = 0; k < BANK_N; k++) begin
      bank_v[bank_pos(k)] = bank_bits[k];
    end
  end

  always_comb begin
    shr_v = '0;
    if (acc_secure) begin
      shr_v[RB_SF_ACT]  = q[F_SF_ACT];
      shr_v[RB_SF_EN]   = q[F_SF_EN];
      shr_v[RB_SF_PEND] = q[F_SF_PEND];
    end
    if (acc_secure || route_ns) begin
      shr_v[RB_BUS_ACT]  = q[F_BUS_ACT];
      shr_v[RB_BUS_PEND] = q[F_BUS_PEND];
      shr_v[RB_BUS_EN]   = q[F_BUS_EN];
      if (!LEGACY) shr_v[RB_NMI_ACT] = q[F_NMI_ACT];
    end
    shr_v[RB_DBG_ACT] = q[F_DBG_ACT];
  end

  assign rdata = rd_en ? (bank_v | shr_v) : '0;

  // R9
  rsv_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & RSV_MASK) == '0);
  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);

endmodule

// File: rtl/shr_bank.sv
module shr_bank
  import shr_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              acc_secure,
  input  logic              cpu_secure,
  input  logic              route_ns,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [FLAG_N-1:0] hw_set,
  input  logic [FLAG_N-1:0] hw_clr,
  output logic [FLAG_N-1:0] flags_o
);

  logic [FLAG_N-1:0] wr_mask;
  logic [FLAG_N-1:0] wr_val;
  logic [FLAG_N-1:0] state;

  shr_wr_decode #(.LEGACY(LEGACY)) u_dec (
    .wr_en      (wr_en),
    .acc_secure (acc_secure),
    .cpu_secure (cpu_secure),
    .route_ns   (route_ns),
    .wdata      (wdata),
    .wr_mask    (wr_mask),
    .wr_val     (wr_val)
  );

  shr_flag_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_mask),
    .wr_val  (wr_val),
    .hw_set  (hw_set),
    .hw_clr  (hw_clr),
    .q       (state)
  );

  shr_read_view #(.LEGACY(LEGACY)) u_view (
    .clk        (clk),
    .rst_n      (rst_n),
    .q          (state),
    .rd_en      (rd_en),
    .acc_secure (acc_secure),
    .route_ns   (route_ns),
    .rdata      (rdata)
  );

  assign flags_o = state;

  // R5
  sec_hard_act_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hw_set[K_HARD_ACT] && !hw_clr[K_HARD_ACT]) |=> $stable(flags_o[K_HARD_ACT]));
  // R7
  nmi_never_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[F_NMI_ACT]) |-> $past(hw_set[F_NMI_ACT]));
  // R7
  ns_hard_act_never_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[NS_BASE + K_HARD_ACT]) |-> $past(hw_set[NS_BASE + K_HARD_ACT]));
  // R2
  sf_hidden_from_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc_secure) |-> (rdata[RB_SF_ACT] | rdata[RB_SF_EN] | rdata[RB_SF_PEND]) == 1'b0);
  // R3
  bus_hidden_unrouted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc_secure && !route_ns)
      |-> (rdata[RB_BUS_ACT] | rdata[RB_BUS_PEND] | rdata[RB_BUS_EN] | rdata[RB_NMI_ACT]) == 1'b0);
  // R2
  sf_ns_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_secure && hw_set[F_SF_ACT] == 1'b0 && hw_clr[F_SF_ACT] == 1'b0)
      |=> $stable(flags_o[F_SF_ACT]));

endmodule

// File: tb/tb_shr_bank.sv
module tb_shr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic        acc_secure = 1'b0, cpu_secure = 1'b0, route_ns = 1'b0;
  logic [31:0] wdata = '0, hw_set = '0, hw_clr = '0;
  logic [31:0] rdata, rdata_l, flags, flags_l;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_st = '0;
  logic [31:0] m_st_l = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shr_bank #(.LEGACY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .acc_secure(acc_secure), .cpu_secure(cpu_secure), .route_ns(route_ns),
    .wdata(wdata), .rdata(rdata), .hw_set(hw_set), .hw_clr(hw_clr), .flags_o(flags));

  shr_bank #(.LEGACY(1'b1)) dut_leg (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .acc_secure(acc_secure), .cpu_secure(cpu_secure), .route_ns(route_ns),
    .wdata(wdata), .rdata(rdata_l), .hw_set(hw_set), .hw_clr(hw_clr), .flags_o(flags_l));

  // register bit of bank field k (R1, R4, R12)
  function automatic int rb(input int k);
    int tbl [12] = '{0, 2, 3, 7, 10, 11, 13, 12, 15, 21, 16, 18};
    return tbl[k];
  endfunction

  // sequencer-reachable flags: all except enables (R11)
  function automatic logic [31:0] hwm();
    logic [31:0] m = '1;
    m[10] = 0; m[11] = 0; m[22] = 0; m[23] = 0; m[26] = 0; m[29] = 0;
    return m;
  endfunction

  function automatic logic [31:0] mwrite(input logic [31:0] st, input logic [31:0] wd,
                                         input bit sec, input bit cpu, input bit rt, input bit leg);
    logic [31:0] s = st;
    int base = sec ? 0 : 12;
    for (int k = 0; k < 12; k++)
      if (k != 1 && k != 9) s[base+k] = wd[rb(k)];
    if (!sec && !leg) s[21] = wd[21];
    if (sec) begin s[27] = wd[4]; s[29] = wd[19]; s[28] = wd[20]; end
    if (sec || rt) begin s[24] = wd[1]; s[25] = wd[14]; s[26] = wd[17]; end
    if (!sec && cpu && rt && !wd[5]) s[30] = 1'b0;
    if (!sec && cpu && rt && !wd[2]) s[13] = 1'b0;
    s[31] = wd[8];
    return s;
  endfunction

  function automatic logic [31:0] mview(input logic [31:0] st, input bit sec,
                                        input bit rt, input bit leg);
    logic [31:0] v = '0;
    int base = sec ? 0 : 12;
    for (int k = 0; k < 12; k++)
      if (sec || !leg || (k != 1 && k != 9)) v[rb(k)] = st[base+k];
    if (sec) begin v[4] = st[27]; v[19] = st[29]; v[20] = st[28]; end
    if (sec || rt) begin
      v[1] = st[24]; v[14] = st[25]; v[17] = st[26];
      if (!leg) v[5] = st[30];
    end
    v[8] = st[31];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: optional write plus sequencer pulses
  task automatic cycle(input bit wr, input logic [31:0] wd, input bit sec, input bit cpu,
                       input bit rt, input logic [31:0] set, input logic [31:0] clr);
    @(negedge clk);
    wr_en = wr; wdata = wd; acc_secure = sec; cpu_secure = cpu; route_ns = rt;
    hw_set = set; hw_clr = clr;
    @(negedge clk);
    wr_en = 0; hw_set = '0; hw_clr = '0;
    m_st   = (m_st   | (set & hwm())) & ~(clr & hwm());
    m_st_l = (m_st_l | (set & hwm())) & ~(clr & hwm());
    if (wr) begin
      m_st   = mwrite(m_st, wd, sec, cpu, rt, 1'b0);
      m_st_l = mwrite(m_st_l, wd, sec, cpu, rt, 1'b1);
    end
  endtask

  task automatic read_chk(input string req, input bit sec, input bit rt);
    rd_en = 1; acc_secure = sec; route_ns = rt;
    #1;
    check(req, rdata, mview(m_st, sec, rt, 1'b0));
    check({req, " legacy"}, rdata_l, mview(m_st_l, sec, rt, 1'b1));
    rd_en = 0;
  endtask

  task automatic state_chk(input string req);
    check(req, flags, m_st);
    check({req, " legacy"}, flags_l, m_st_l);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pats [6] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h5555_5555,
                              32'hAAAA_AAAA, 32'h0F0F_F0F0, 32'h3C5A_A5C3};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    state_chk("R9 reset state");
    read_chk("R9 reset read secure", 1'b1, 1'b1);
    read_chk("R9 reset read non-secure", 1'b0, 1'b0);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: sweep of patterns and attribute combinations
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 8; c++) begin
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, '0);
        cycle(1'b1, pats[p], c[0], c[1], c[2], '0, '0);
        state_chk("R1 R2 R3 R5 R6 R7 R8 state after write");
        for (int v = 0; v < 4; v++)
          read_chk("R1 R2 R3 R4 R8 R9 view", v[0], v[1]);
      end
    end

    // R7: clear-only write succeeds under the exact condition
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, '0);
    cycle(1'b1, 32'h0, 1'b0, 1'b1, 1'b1, '0, '0);
    check("R7 nmi cleared", {31'b0, flags[30]}, 32'd0);
    check("R7 ns hard active cleared", {31'b0, flags[13]}, 32'd0);
    // R7: cpu non-secure leaves both flags set
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, '0);
    cycle(1'b1, 32'h0, 1'b0, 1'b0, 1'b1, '0, '0);
    check("R7 nmi kept", {31'b0, flags[30]}, 32'd1);
    check("R7 ns hard active kept", {31'b0, flags[13]}, 32'd1);
    // R7: writing ones never sets them
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 32'hFFFF_FFFF);
    cycle(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, '0, '0);
    check("R7 nmi not set", {31'b0, flags[30]}, 32'd0);
    state_chk("R7 state");

    // R5: secure write of zeros leaves secure hard active and pending set
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, '0);
    cycle(1'b1, 32'h0, 1'b1, 1'b1, 1'b1, '0, '0);
    check("R5 secure hard bits", {30'b0, flags[9], flags[1]}, 32'd3);

    // R6: non-secure write of bit 21 only in non-legacy
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 32'hFFFF_FFFF);
    cycle(1'b1, 32'h0020_0000, 1'b0, 1'b0, 1'b0, '0, '0);
    check("R6 ns hard pending set", {31'b0, flags[21]}, 32'd1);
    check("R6 ns hard pending legacy ignored", {31'b0, flags_l[21]}, 32'd0);

    // R8: debug active written non-secure, read secure
    cycle(1'b1, 32'h0000_0100, 1'b0, 1'b0, 1'b0, '0, '0);
    read_chk("R8 debug shared", 1'b1, 1'b0);

    // R11: set and clear together, clear wins, enables untouched
    cycle(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, '0, '0);
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R11 clear wins, enables kept", flags, ~hwm() & m_st);
    check("R11 enables kept", flags & ~hwm(), 32'h0000_0C00 | 32'h2400_0000 | (m_st & ~hwm()));
    state_chk("R11 state");
    // R11: register write beats sequencer set
    cycle(1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, '0);
    check("R11 write wins", {31'b0, flags[0]}, 32'd0);
    check("R11 unwritten set", {31'b0, flags[12]}, 32'd1);
    state_chk("R11 R12 state");

    // R10: idle read is zero
    rd_en = 0; acc_secure = 1; route_ns = 1;
    #1;
    check("R10 idle read", rdata, 32'd0);
    check("R10 idle read legacy", rdata_l, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule